// File: doc/BRIEF.md
# Dual-Mode SPI Register Slave

This block lets an external SPI master read and write a small bank of byte registers. Every access opens with a command byte that carries a register address and a direction flag. Data bytes then follow for as long as the master keeps the select line low and keeps toggling the serial clock. The address steps forward after each byte, so one access can cover several registers in a single burst.

The data pins work in one of two ways, chosen by a bit in a configuration register. In four-wire (full-duplex) mode, input and output use separate lines. The slave shifts an 8-bit status word out on the output line while the command byte is still arriving. In three-wire (half-duplex) mode, one line carries data both ways. The dedicated output line stays released, and the slave drives the shared line only while it returns read data. The serial pins are brought into the system clock domain through a two-flop synchroniser. All SPI edges are recovered in that domain.

Top module: `spi_dual_slave`

## Requirements
- R1: After reset every storage register reads 0x00, the block is in half-duplex mode, and both output enables are low.
- R2: While `ss_n` is high, `miso_oe` and `sdio_oe` are low.
- R3: In full-duplex mode, once `ss_n` falls, `miso_oe` goes high and `miso_out` shows bit 7 of `status_i` (sampled at the select edge) before the first SCLK rise. Bits 6 down to 0 follow on the next seven SCLK falling edges.
- R4: Command byte layout: bits 7:3 are the register address and bit 1 is the direction (1 = write, 0 = read). Bits 2 and 0 have no effect.
- R5: In a write burst, each complete data byte is stored at the current address, and the address then increments modulo 32. In full-duplex mode `miso_out` is 0 during the data bytes.
- R6: In a full-duplex read burst, register bytes follow the command byte MSB first at consecutive addresses. The SCLK falling edge that ends a byte presents the MSB of the next byte. Input data is ignored.
- R7: Address 0 returns `status_i` and ignores writes. Addresses 1 to NUM_REGS (default 4) are storage. Higher addresses read 0x00 and ignore writes.
- R8: Bit 0 of the register at address 1 selects the mode: 1 is full-duplex and 0 is half-duplex. A change takes effect at the next falling edge of `ss_n`.
- R9: In half-duplex mode `miso_oe` stays low and nothing is shifted out during the command byte. On a read, `sdio_oe` rises at the SCLK falling edge after the command byte and `sdio_out` carries the read bytes. On a write, `sdio_oe` stays low. The two enables are never high together.
- R10: A data byte cut short by `ss_n` rising is discarded, and no register changes.
- R11: Incoming data is sampled on SCLK rising edges. Outgoing data changes only on SCLK falling edges or on the select edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_n | input | 1 | Slave select, active low |
| sclk | input | 1 | Serial clock from the master, idles low |
| sdi | input | 1 | Serial data in (dedicated input in four-wire mode, shared line in three-wire mode) |
| status_i | input | 8 | Status word shifted out during the command byte and readable at address 0 |
| miso_out | output | 1 | Dedicated serial data out |
| miso_oe | output | 1 | Output enable for the dedicated data-out line |
| sdio_out | output | 1 | Value driven onto the shared line in three-wire mode |
| sdio_oe | output | 1 | Output enable for the shared line |

## Verification
The assertions assume that SCLK is low when select falls and that each SCLK and select level lasts well beyond the synchroniser latency of three system clocks. They also assume that `status_i` does not change while an access is in progress. The stimulus holds each SCLK phase for eight system clocks and moves the data line only while SCLK is low. It changes the status word only between accesses and leaves the clock low across every select edge. Within those limits, the checks on edge ordering and on output enables are made on the synchronised edge events rather than on the raw pins.

// File: rtl/dspi_pkg.sv
`timescale 1ns/1ps
package dspi_pkg;
    localparam int BYTE_W       = 8;
    localparam int ADDR_W       = 5;
    localparam int CMD_ADDR_LSB = 3;
    localparam int CMD_WR_BIT   = 1;
    localparam int CFG_ADDR     = 1;
    localparam int CFG_FD_BIT   = 0;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;
endpackage

// File: rtl/dspi_pin_sync.sv
`timescale 1ns/1ps
module dspi_pin_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.chain = {state_q.chain[CHAIN_W-2:0], pin_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.chain <= {CHAIN_W{RESET_VAL}};
        end else begin
            state_q <= state_d;
        end
    end

    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    assign level_o = state_q.chain[CHAIN_W-2];
    assign rise_o  = state_q.chain[CHAIN_W-2] & ~state_q.chain[CHAIN_W-1];
    assign fall_o  = ~state_q.chain[CHAIN_W-2] & state_q.chain[CHAIN_W-1];
endmodule

// File: rtl/dspi_regbank.sv
`timescale 1ns/1ps
module dspi_regbank
    import dspi_pkg::*;
#(
    parameter int NUM_REGS = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  addr_t wr_addr,
    input  byte_t wr_data,
    input  addr_t rd_addr,
    input  byte_t status_i,
    output byte_t rd_data,
    output logic  fd_mode_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][BYTE_W-1:0] mem;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_addr == addr_t'(i + 1)) begin
                    bank_d.mem[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == addr_t'(0)) begin
            rd_data = status_i;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (rd_addr == addr_t'(i + 1)) begin
                    rd_data = bank_q.mem[i];
                end
            end
        end
    end

    assign fd_mode_o = bank_q.mem[CFG_ADDR-1][CFG_FD_BIT];
endmodule

// File: rtl/dspi_xfer_ctrl.sv
`timescale 1ns/1ps
module dspi_xfer_ctrl
    import dspi_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  ss_lvl,
    input  logic  ss_fall,
    input  logic  sclk_rise,
    input  logic  sclk_fall,
    input  logic  sdi_lvl,
    input  logic  fd_cfg,
    input  byte_t status_i,
    input  byte_t rd_data,
    output addr_t rd_addr,
    output logic  wr_en,
    output addr_t wr_addr,
    output byte_t wr_data,
    output logic  miso_out,
    output logic  miso_oe,
    output logic  sdio_out,
    output logic  sdio_oe
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam int RX_W  = BYTE_W - 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        phase_e          phase;
        logic            fd;
        logic            is_wr;
        logic [CNT_W-1:0] bitcnt;
        logic [RX_W-1:0] rx;
        byte_t           tx;
        byte_t           nxt;
        logic            load_pend;
        addr_t           addr;
        logic            miso_oe;
        logic            sdio_oe;
    } xfer_t;

    xfer_t x_d, x_q;
    byte_t rx_full;

    always_comb begin
        x_d     = x_q;
        rx_full = {x_q.rx, sdi_lvl};
        wr_en   = 1'b0;
        wr_addr = x_q.addr;
        wr_data = rx_full;
        rd_addr = (x_q.phase == PH_CMD) ? rx_full[BYTE_W-1:CMD_ADDR_LSB] : x_q.addr + addr_t'(1);

        if (ss_lvl) begin
            x_d.phase     = PH_IDLE;
            x_d.bitcnt    = '0;
            x_d.load_pend = 1'b0;
            x_d.miso_oe   = 1'b0;
            x_d.sdio_oe   = 1'b0;
        end else if (ss_fall) begin
            x_d.phase     = PH_CMD;
            x_d.fd        = fd_cfg;
            x_d.is_wr     = 1'b0;
            x_d.bitcnt    = '0;
            x_d.tx        = status_i;
            x_d.load_pend = 1'b0;
            x_d.miso_oe   = fd_cfg;
            x_d.sdio_oe   = 1'b0;
        end else if (x_q.phase != PH_IDLE) begin
            if (sclk_rise) begin
                x_d.rx     = rx_full[RX_W-1:0];
                x_d.bitcnt = x_q.bitcnt + 1'b1;
                if (x_q.bitcnt == LAST_BIT) begin
                    x_d.load_pend = 1'b1;
                    if (x_q.phase == PH_CMD) begin
                        x_d.phase = PH_DATA;
                        x_d.addr  = rx_full[BYTE_W-1:CMD_ADDR_LSB];
                        x_d.is_wr = rx_full[CMD_WR_BIT];
                        x_d.nxt   = rx_full[CMD_WR_BIT] ? '0 : rd_data;
                    end else begin
                        if (x_q.is_wr) begin
                            wr_en   = 1'b1;
                            x_d.nxt = '0;
                        end else begin
                            x_d.nxt = rd_data;
                        end
                        x_d.addr = x_q.addr + addr_t'(1);
                    end
                end
            end else if (sclk_fall) begin
                if (x_q.load_pend) begin
                    x_d.tx        = x_q.nxt;
                    x_d.load_pend = 1'b0;
                    if (!x_q.fd && (x_q.phase == PH_DATA) && !x_q.is_wr) begin
                        x_d.sdio_oe = 1'b1;
                    end
                end else begin
                    x_d.tx = {x_q.tx[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q       <= '0;
            x_q.phase <= PH_IDLE;
        end else begin
            x_q <= x_d;
        end
    end

    assign miso_out = x_q.miso_oe & x_q.tx[BYTE_W-1];
    assign miso_oe  = x_q.miso_oe;
    assign sdio_out = x_q.sdio_oe & x_q.tx[BYTE_W-1];
    assign sdio_oe  = x_q.sdio_oe;
endmodule

// File: rtl/spi_dual_slave.sv
`timescale 1ns/1ps
module spi_dual_slave
    import dspi_pkg::*;
#(
    parameter int NUM_REGS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic [BYTE_W-1:0] status_i,
    output logic              miso_out,
    output logic              miso_oe,
    output logic              sdio_out,
    output logic              sdio_oe
);
    localparam int NPIN = 3;
    // pin order: 0 = sclk, 1 = ss_n, 2 = sdi; select resets to the idle (high) level
    localparam logic [NPIN-1:0] PIN_RST = 3'b010;

    logic [NPIN-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
    logic  ss_lvl, ss_fall, sclk_rise, sclk_fall, sdi_lvl;
    logic  fd_cfg, wr_en;
    addr_t wr_addr, rd_addr;
    byte_t wr_data, rd_data;
    logic  unused_edges;

    assign pin_raw = {sdi, ss_n, sclk};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        dspi_pin_sync #(
            .STAGES   (SYNC_STAGES),
            .RESET_VAL(PIN_RST[g])
        ) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_raw[g]),
            .level_o(pin_lvl[g]),
            .rise_o (pin_rise[g]),
            .fall_o (pin_fall[g])
        );
    end

    assign sclk_rise    = pin_rise[0];
    assign sclk_fall    = pin_fall[0];
    assign ss_lvl       = pin_lvl[1];
    assign ss_fall      = pin_fall[1];
    assign sdi_lvl      = pin_lvl[2];
    assign unused_edges = ^{pin_lvl[0], pin_rise[1], pin_rise[2], pin_fall[2]};

    dspi_regbank #(
        .NUM_REGS(NUM_REGS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .status_i (status_i),
        .rd_data  (rd_data),
        .fd_mode_o(fd_cfg)
    );

    dspi_xfer_ctrl u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ss_lvl   (ss_lvl),
        .ss_fall  (ss_fall),
        .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall),
        .sdi_lvl  (sdi_lvl),
        .fd_cfg   (fd_cfg),
        .status_i (status_i),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .miso_out (miso_out),
        .miso_oe  (miso_oe),
        .sdio_out (sdio_out),
        .sdio_oe  (sdio_oe)
    );
endmodule

// File: rtl/dspi_checker.sv
`timescale 1ns/1ps
module dspi_checker (
    input logic clk,
    input logic rst_n,
    input logic ss_lvl,
    input logic ss_fall,
    input logic sclk_fall,
    input logic fd_cfg,
    input logic status_bit7,
    input logic miso_out,
    input logic miso_oe,
    input logic sdio_oe
);
    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_lvl |=> (!miso_oe && !sdio_oe));

    // R3
    fd_first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_fall && fd_cfg) |=> (miso_oe && (miso_out == $past(status_bit7))));

    // R9
    single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(miso_oe && sdio_oe));

    // R9
    sdio_turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdio_oe) |-> $past(sclk_fall));

    // R11
    miso_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe) && (miso_out != $past(miso_out))) |-> $past(sclk_fall));
endmodule

bind spi_dual_slave dspi_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ss_lvl     (ss_lvl),
    .ss_fall    (ss_fall),
    .sclk_fall  (sclk_fall),
    .fd_cfg     (fd_cfg),
    .status_bit7(status_i[7]),
    .miso_out   (miso_out),
    .miso_oe    (miso_oe),
    .sdio_oe    (sdio_oe)
);

// File: tb/tb_spi_dual_slave.sv
`timescale 1ns/1ps
module tb_spi_dual_slave;
    localparam int NUM_REGS = 4;
    localparam int HALF     = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ss_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic [7:0] status = 8'h00;
    logic       miso_out, miso_oe, sdio_out, sdio_oe;

    int checks = 0;
    int errors = 0;
    int idle_cnt = 0;
    logic [7:0] model_mem [1:NUM_REGS];
    logic       model_fd = 1'b0;

    always #2.5 clk = ~clk;

    spi_dual_slave #(.NUM_REGS(NUM_REGS)) dut (
        .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sclk(sclk), .sdi(sdi),
        .status_i(status), .miso_out(miso_out), .miso_oe(miso_oe),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] model_read(input logic [4:0] a);
        if (a == 5'd0) return status;
        if (int'(a) <= NUM_REGS) return model_mem[int'(a)];
        return 8'h00;
    endfunction

    // R2: deselected block leaves both data lines released
    always @(negedge clk) begin
        idle_cnt = ss_n ? idle_cnt + 1 : 0;
        if (rst_n && idle_cnt >= 5)
            check(!miso_oe && !sdio_oe, "R2", "oe while deselected", {miso_oe, sdio_oe}, 0);
    end

    task automatic shift_byte(input logic [7:0] mo, input int nbits, input logic [7:0] exp,
                              input logic exp_moe, input logic exp_soe, input string req);
        for (int i = 0; i < nbits; i++) begin
            logic m_before, s_before;
            sdi = mo[7-i];
            waitc(HALF);
            check(miso_oe === exp_moe, req, "miso_oe", miso_oe, exp_moe);
            check(sdio_oe === exp_soe, req, "sdio_oe", sdio_oe, exp_soe);
            if (exp_moe) check(miso_out === exp[7-i], req, "miso bit", miso_out, exp[7-i]);
            if (exp_soe) check(sdio_out === exp[7-i], req, "sdio bit", sdio_out, exp[7-i]);
            m_before = miso_out;
            s_before = sdio_out;
            sclk = 1'b1;
            waitc(HALF - 2);
            // R11: outputs hold across the rising edge
            check(miso_out === m_before && sdio_out === s_before, "R11", "stable across rise",
                  {miso_out, sdio_out}, {m_before, s_before});
            waitc(2);
            sclk = 1'b0;
        end
    endtask

    task automatic access(input bit wr, input logic [4:0] addr, input logic [1:0] junk,
                          input int n, input logic [7:0] wb [8], input int partial,
                          input string req);
        logic [7:0] cmdb;
        logic       fd;
        logic [4:0] a;
        fd   = model_fd;
        a    = addr;
        cmdb = {addr, junk[1], wr, junk[0]};
        ss_n = 1'b0;
        shift_byte(cmdb, 8, status, fd, 1'b0, fd ? "R3" : "R9");
        for (int k = 0; k < n; k++) begin
            if (wr) begin
                shift_byte(wb[k], 8, 8'h00, fd, 1'b0, req);
                if (a >= 5'd1 && int'(a) <= NUM_REGS) model_mem[int'(a)] = wb[k];
            end else begin
                shift_byte(8'hA7, 8, model_read(a), fd, !fd, req);
            end
            a = a + 5'd1;
        end
        if (partial > 0)
            shift_byte(8'hFF, partial, wr ? 8'h00 : model_read(a), fd, !wr && !fd, "R10");
        waitc(HALF);
        ss_n = 1'b1;
        waitc(2 * HALF);
        model_fd = model_mem[1][0];
    endtask

    initial begin
        for (int i = 1; i <= NUM_REGS; i++) model_mem[i] = 8'h00;
        waitc(5);
        check(!miso_oe && !sdio_oe, "R1", "oe during reset", {miso_oe, sdio_oe}, 0);
        rst_n = 1'b1;
        waitc(6);
        check(!miso_oe && !sdio_oe, "R1", "oe after reset", {miso_oe, sdio_oe}, 0);

        // R1: storage clear, half-duplex read path
        access(1'b0, 5'd1, 2'b00, NUM_REGS, '{default: 8'h00}, 0, "R1");

        // R5 / R9: half-duplex write burst then read back on the shared line
        access(1'b1, 5'd2, 2'b00, 2, '{8'hA5, 8'h3C, 0, 0, 0, 0, 0, 0}, 0, "R5");
        access(1'b0, 5'd2, 2'b00, 2, '{default: 8'h00}, 0, "R9");

        // R8: set full-duplex; the same access still runs half-duplex
        access(1'b1, 5'd1, 2'b00, 1, '{8'h01, 0, 0, 0, 0, 0, 0, 0}, 0, "R8");

        // R3 / R6: full-duplex status and read burst
        status = 8'hC6;
        waitc(4);
        access(1'b0, 5'd2, 2'b00, 3, '{default: 8'h00}, 0, "R6");

        // R4: reserved command bits set
        status = 8'h5A;
        waitc(4);
        access(1'b0, 5'd3, 2'b11, 1, '{default: 8'h00}, 0, "R4");
        access(1'b1, 5'd4, 2'b11, 1, '{8'hE1, 0, 0, 0, 0, 0, 0, 0}, 0, "R4");
        access(1'b0, 5'd4, 2'b00, 1, '{default: 8'h00}, 0, "R4");

        // R5 / R7: wrap through out-of-range and status addresses
        status = 8'h3B;
        waitc(4);
        access(1'b1, 5'd31, 2'b00, 3, '{8'h77, 8'h99, 8'h55, 0, 0, 0, 0, 0}, 0, "R5");
        access(1'b0, 5'd30, 2'b00, 4, '{default: 8'h00}, 0, "R7");

        // R10: burst cut mid-byte
        access(1'b1, 5'd3, 2'b00, 1, '{8'h11, 0, 0, 0, 0, 0, 0, 0}, 4, "R10");
        access(1'b0, 5'd3, 2'b00, 2, '{default: 8'h00}, 0, "R10");

        // R7: read past the storage end
        access(1'b0, 5'd3, 2'b00, 4, '{default: 8'h00}, 3, "R7");

        // R8: clear the mode bit, next access is half-duplex
        access(1'b1, 5'd1, 2'b00, 1, '{8'h00, 0, 0, 0, 0, 0, 0, 0}, 0, "R8");
        access(1'b0, 5'd2, 2'b00, 2, '{default: 8'h00}, 0, "R8");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule